// File: doc/BRIEF.md
# Encoder-Gated Revolution Integrator

This block sums demodulated in-phase and quadrature samples over exactly one turn of a turntable. The turn is marked by a mechanical encoder that supplies a once-per-turn zero mark and a multiplied step train. Zero mark and step train reach the block as asynchronous levels. The block takes one sample of each channel on every step edge. It integrates from one zero mark to the next and then latches the two sums and the number of steps taken into result registers for a host processor.

The host arms the block once. It then polls a data-good flag. When the flag is set, the host reads the result registers and pulses a read strobe. The strobe clears the flag and re-arms the block, which waits for a fresh zero mark. The zero mark that closed a window does not open a new one, so a read always gets a whole turn. The sample inputs have no valid/ready handshake. They are level-held words from the upstream filter, taken at the moment a step edge is detected, and the block never applies back-pressure. The result side is a register set guarded by the flag rather than a stream.

Top module: `rev_integrator`

## Requirements
- R1: After reset, data_good is 0, sum_i and sum_q are 0, sum_cnt is 0, and the block is disarmed.
- R2: While disarmed, zero marks, steps and read strobes change nothing. Only an arm_req pulse arms the block.
- R3: Once armed, the window opens on the first rising edge of enc_zero. Steps before that edge are not summed.
- R4: Inside the window, each rising edge of enc_step adds the two's-complement values on smp_i and smp_q to their sums, sign-extended, and adds one to the step count.
- R5: The next rising edge of enc_zero closes the window. The sums and the step count are copied into sum_i, sum_q and sum_cnt, and data_good rises. This happens within four clocks of the enc_zero edge, and the result outputs change at no other time.
- R6: While data_good is high and no read strobe comes, the results and the flag hold, whatever the encoder pins do.
- R7: A host_rd pulse while data_good is high clears data_good on the next clock. The block re-arms, and the next window opens on the next enc_zero edge after that.
- R8: Once MAX_STEPS steps have been summed in a window, further steps in that window are ignored and sum_cnt stays at MAX_STEPS.
- R9: A step edge in the same clock as the closing zero edge is not summed.
- R10: The sums are SAMPLE_W + log2(MAX_STEPS) bits wide, so a full window of extreme samples cannot overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| arm_req | input | 1 | One-clock pulse that arms the block from the disarmed state |
| enc_zero | input | 1 | Asynchronous once-per-turn zero mark |
| enc_step | input | 1 | Asynchronous multiplied step train |
| smp_i | input | SAMPLE_W | Filtered in-phase sample, two's complement |
| smp_q | input | SAMPLE_W | Filtered quadrature sample, two's complement |
| host_rd | input | 1 | Read-done strobe from the host |
| data_good | output | 1 | Results valid and held |
| sum_i | output | SAMPLE_W+log2(MAX_STEPS) | Latched in-phase sum |
| sum_q | output | SAMPLE_W+log2(MAX_STEPS) | Latched quadrature sum |
| sum_cnt | output | log2(MAX_STEPS+1) | Steps summed in the last window |

## Verification
The bench builds the block with SAMPLE_W = 8 and MAX_STEPS = 8. These small values let it sweep every window length from zero steps through two beyond the step limit, so the saturation boundary is crossed from both sides. Sample values are spread across the whole 8-bit range, including -128 and 127, so that sign extension and worst-case sums are exercised. The sweep also covers the disarmed state, steps that arrive before the opening mark, pin activity while results are held, and a step edge that coincides with the closing mark.

// File: rtl/rev_pkg.sv
`timescale 1ns/1ps
package rev_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_ACC   = 2'd2,
    ST_DONE  = 2'd3
  } rev_state_e;
endpackage

// File: rtl/rev_edge_sync.sv
`timescale 1ns/1ps
module rev_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], raw};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/rev_window_ctl.sv
`timescale 1ns/1ps
module rev_window_ctl
  import rev_pkg::*;
#(
  parameter int MAX_STEPS = 1024,
  parameter int CNT_W     = $clog2(MAX_STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_req,
  input  logic             zero_rise,
  input  logic             step_rise,
  input  logic             host_rd,
  output logic             acc_clr,
  output logic             acc_add,
  output logic             latch,
  output logic             data_good,
  output logic [CNT_W-1:0] run_cnt
);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_STEPS);

  rev_state_e state;

  assign acc_clr = (state == ST_ARMED) && zero_rise;
  assign latch   = (state == ST_ACC) && zero_rise;
  assign acc_add = (state == ST_ACC) && step_rise && !zero_rise
                   && (run_cnt < CNT_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      data_good <= 1'b0;
      run_cnt   <= '0;
    end else begin
      if (acc_clr)      run_cnt <= '0;
      else if (acc_add) run_cnt <= run_cnt + 1'b1;
      unique case (state)
        ST_IDLE:  if (arm_req) state <= ST_ARMED;
        ST_ARMED: if (zero_rise) state <= ST_ACC;
        ST_ACC: if (zero_rise) begin
          state     <= ST_DONE;
          data_good <= 1'b1;
        end
        ST_DONE: if (host_rd) begin
          state     <= ST_ARMED;
          data_good <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rev_acc_lane.sv
`timescale 1ns/1ps
module rev_acc_lane #(
  parameter int IN_W  = 24,
  parameter int ACC_W = 34
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    add,
  input  logic signed [IN_W-1:0]  sample,
  output logic signed [ACC_W-1:0] acc
);
  localparam int EXT_W = ACC_W - IN_W;

  logic signed [ACC_W-1:0] sample_ext;
  assign sample_ext = {{EXT_W{sample[IN_W-1]}}, sample};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else if (add) acc <= acc + sample_ext;
  end
endmodule

// File: rtl/rev_integrator.sv
`timescale 1ns/1ps
module rev_integrator #(
  parameter int SAMPLE_W  = 24,
  parameter int MAX_STEPS = 1024,
  parameter int SYNC_LEN  = 2,
  localparam int ACC_W    = SAMPLE_W + $clog2(MAX_STEPS),
  localparam int CNT_W    = $clog2(MAX_STEPS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm_req,
  input  logic                enc_zero,
  input  logic                enc_step,
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic [SAMPLE_W-1:0] smp_q,
  input  logic                host_rd,
  output logic                data_good,
  output logic [ACC_W-1:0]    sum_i,
  output logic [ACC_W-1:0]    sum_q,
  output logic [CNT_W-1:0]    sum_cnt
);
  localparam int N_PINS  = 2;
  localparam int N_LANES = 2;

  logic [N_PINS-1:0] pin_raw, pin_rise;
  logic zero_rise, step_rise;
  logic acc_clr, acc_add, latch;
  logic [CNT_W-1:0] run_cnt;
  logic [N_LANES-1:0][SAMPLE_W-1:0] lane_in;
  logic [N_LANES-1:0][ACC_W-1:0]    lane_acc;

  assign pin_raw   = {enc_step, enc_zero};
  assign zero_rise = pin_rise[0];
  assign step_rise = pin_rise[1];
  assign lane_in   = {smp_q, smp_i};

  for (genvar p = 0; p < N_PINS; p++) begin : g_sync
    rev_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (pin_raw[p]),
      .rise (pin_rise[p])
    );
  end

  rev_window_ctl #(.MAX_STEPS(MAX_STEPS), .CNT_W(CNT_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_req  (arm_req),
    .zero_rise(zero_rise),
    .step_rise(step_rise),
    .host_rd  (host_rd),
    .acc_clr  (acc_clr),
    .acc_add  (acc_add),
    .latch    (latch),
    .data_good(data_good),
    .run_cnt  (run_cnt)
  );

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    rev_acc_lane #(.IN_W(SAMPLE_W), .ACC_W(ACC_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (acc_clr),
      .add   (acc_add),
      .sample(lane_in[l]),
      .acc   (lane_acc[l])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_i   <= '0;
      sum_q   <= '0;
      sum_cnt <= '0;
    end else if (latch) begin
      sum_i   <= lane_acc[0];
      sum_q   <= lane_acc[1];
      sum_cnt <= run_cnt;
    end
  end
endmodule

// File: rtl/rev_integrator_chk.sv
`timescale 1ns/1ps
module rev_integrator_chk #(
  parameter int ACC_W     = 34,
  parameter int CNT_W     = 11,
  parameter int MAX_STEPS = 1024
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_rd,
  input logic             data_good,
  input logic             zero_rise,
  input logic [ACC_W-1:0] sum_i,
  input logic [ACC_W-1:0] sum_q,
  input logic [CNT_W-1:0] sum_cnt
);
  // R5
  good_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_good) |-> $past(zero_rise));

  // R5
  cnt_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(data_good) |-> $stable(sum_cnt));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_good && !host_rd) |=> (data_good && $stable(sum_i)
                                 && $stable(sum_q) && $stable(sum_cnt)));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_good && host_rd) |=> !data_good);

  // R8
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_cnt <= CNT_W'(MAX_STEPS));
endmodule

bind rev_integrator rev_integrator_chk #(
  .ACC_W(ACC_W), .CNT_W(CNT_W), .MAX_STEPS(MAX_STEPS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .host_rd  (host_rd),
  .data_good(data_good),
  .zero_rise(zero_rise),
  .sum_i    (sum_i),
  .sum_q    (sum_q),
  .sum_cnt  (sum_cnt)
);

// File: tb/tb_rev_integrator.sv
`timescale 1ns/1ps
module tb_rev_integrator;
  localparam int SW = 8;
  localparam int NM = 8;
  localparam int AW = SW + $clog2(NM);
  localparam int CW = $clog2(NM + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_req = 1'b0, enc_zero = 1'b0, enc_step = 1'b0, host_rd = 1'b0;
  logic [SW-1:0] smp_i = '0, smp_q = '0;
  logic data_good;
  logic [AW-1:0] sum_i, sum_q;
  logic [CW-1:0] sum_cnt;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rev_integrator #(.SAMPLE_W(SW), .MAX_STEPS(NM)) dut (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .enc_zero(enc_zero),
    .enc_step(enc_step), .smp_i(smp_i), .smp_q(smp_q), .host_rd(host_rd),
    .data_good(data_good), .sum_i(sum_i), .sum_q(sum_q), .sum_cnt(sum_cnt)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int si(int k, int j);
    return ((k * 53 + j * 97 + 3) % 256) - 128;
  endfunction

  function automatic int sq(int k, int j);
    return 127 - ((k * 29 + j * 71) % 256);
  endfunction

  task automatic step(int vi, int vq);
    smp_i = vi[SW-1:0];
    smp_q = vq[SW-1:0];
    enc_step = 1'b1; tick(3);
    enc_step = 1'b0; tick(3);
  endtask

  task automatic zero_mark;
    enc_zero = 1'b1; tick(3);
    enc_zero = 1'b0; tick(3);
  endtask

  task automatic host_read;
    host_rd = 1'b1; tick(1);
    host_rd = 1'b0; tick(1);
  endtask

  task automatic check_res(string tag, int ec, int ei, int eq);
    chk({tag, " data_good"}, int'(data_good), 1);
    chk({tag, " sum_cnt"}, int'(sum_cnt), ec);
    chk({tag, " sum_i"}, int'($signed(sum_i)), ei);
    chk({tag, " sum_q"}, int'($signed(sum_q)), eq);
  endtask

  // opens a window, applies n steps of pattern k, closes it
  task automatic run_window(string tag, int k, int n);
    int ei = 0, eq = 0;
    zero_mark();
    for (int j = 0; j < n; j++) begin
      step(si(k, j), sq(k, j));
      if (j < NM) begin ei += si(k, j); eq += sq(k, j); end
    end
    zero_mark();
    check_res(tag, (n < NM) ? n : NM, ei, eq);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    chk("R1 data_good", int'(data_good), 0);
    chk("R1 sum_i", int'(sum_i), 0);
    chk("R1 sum_q", int'(sum_q), 0);
    chk("R1 sum_cnt", int'(sum_cnt), 0);
    rst_n = 1'b1;
    tick(2);

    // R2 disarmed: read strobe, marks and steps do nothing
    host_read();
    zero_mark();
    step(5, 5); step(7, 7);
    zero_mark();
    zero_mark();
    chk("R2 data_good stays low", int'(data_good), 0);
    chk("R2 sum_cnt", int'(sum_cnt), 0);

    arm_req = 1'b1; tick(1); arm_req = 1'b0; tick(1);

    // R3 steps before the opening mark are not summed
    step(100, -100); step(-50, 60);
    chk("R3 no early result", int'(data_good), 0);
    run_window("R3 R4 R5 first window", 0, 3);

    // R6 hold under pin activity
    zero_mark(); step(33, 44); zero_mark(); tick(5);
    begin
      int ei = si(0, 0) + si(0, 1) + si(0, 2);
      int eq = sq(0, 0) + sq(0, 1) + sq(0, 2);
      check_res("R6 held", 3, ei, eq);
    end

    // R7 read clears flag
    host_read();
    chk("R7 data_good cleared", int'(data_good), 0);
    step(9, 9);
    chk("R7 waits for mark", int'(data_good), 0);

    // R4 R8 sweep window length across the limit
    for (int n = 0; n <= NM + 2; n++) begin
      run_window(n > NM ? "R8 over limit" : "R4 sweep", n + 1, n);
      host_read();
      chk("R7 cleared in sweep", int'(data_good), 0);
    end

    // R10 extreme samples over a full window
    begin
      zero_mark();
      for (int j = 0; j < NM; j++) step(-128, 127);
      zero_mark();
      check_res("R10 extreme", NM, -128 * NM, 127 * NM);
      host_read();
    end

    // R9 step coincident with closing mark
    zero_mark();
    step(10, -3); step(20, -4);
    smp_i = 8'd77; smp_q = 8'd77;
    enc_zero = 1'b1; enc_step = 1'b1; tick(3);
    enc_zero = 1'b0; enc_step = 1'b0; tick(3);
    check_res("R9 coincident", 2, 30, -7);
    host_read();

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule